// File: doc/BRIEF.md
# Effective Address Generation Unit

This block forms the 32-bit operand address for a CPU that holds eight 32-bit address registers. Each access presents an addressing mode, a register index, a field taken from the instruction (a displacement or an absolute address, with a tag that gives its width), the operand size, the current program counter and a flag that marks an instruction-fetch address. From these the block computes the effective address, a misalignment flag and, for the auto-modifying modes, the value that goes back into the register.

The address arithmetic is combinational. The eight address registers sit in a small registered array inside the block. A load port writes a register directly, and a read port shows any register's contents. When the access strobe is high in an auto-modifying mode, the new register value is stored at the next rising clock edge.

Top module: `ea_unit`

## Requirements
- R1: Mode 0 (register indirect) gives an effective address equal to the selected register. When `fetch_i` is 1 in any register-based mode (0 to 3), bits 31:24 of the effective address are forced to 0 and bits 23:0 are kept.
- R2: Mode 1 (displacement) adds the field to the register. With size tag 1 the low 16 bits of the field are sign-extended first. With any other tag the whole 32-bit field is added unchanged.
- R3: Mode 2 (post-increment) gives the unmodified register as the effective address. The write-back value is the register plus 1, 2 or 4 for operand size 0 (byte), 1 (word) or 2/3 (longword).
- R4: Mode 3 (pre-decrement) subtracts 1, 2 or 4, chosen by operand size as in R3, from the register. The difference is both the effective address and the write-back value.
- R5: Mode 4 (absolute) extends the field by its size tag:
  - tag 0: bits 31:8 set to ones, low 8 bits kept;
  - tag 1: the low 16 bits sign-extended;
  - tag 2: bits 31:24 forced to zero, low 24 bits kept;
  - tag 3: all 32 bits used as given.
- R6: Mode 5 (PC-relative) adds a displacement to `pc_i`. With tag 0 the displacement is the low 8 bits of the field, sign-extended. With any other tag it is the low 16 bits, sign-extended.
- R7: `wb_en_o` is 1 only in modes 2 and 3. The selected register takes `wb_val_o` at the rising edge where `step_i` and `wb_en_o` are both 1. In every other mode, and whenever `step_i` is 0, the register keeps its value.
- R8: `misalign_o` is 1 exactly when the operand size is not byte (size not 0) and bit 0 of the effective address is 1. The address and the write-back value are still produced.
- R9: Reset clears all registers to zero. The register chosen by `ld_idx_i` takes `ld_val_i` on a rising edge where `ld_en_i` is 1. If a load and a write-back target the same register in one cycle, the load wins. `rd_val_o` shows register `rd_idx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Access strobe that commits write-back |
| mode_i | input | 3 | Addressing mode code |
| reg_i | input | 3 | Address register index |
| field_i | input | 32 | Displacement or absolute field |
| fsz_i | input | 2 | Field size tag (0:8, 1:16, 2:24, 3:32 bits) |
| opsz_i | input | 2 | Operand size (0 byte, 1 word, 2/3 longword) |
| pc_i | input | 32 | Current program counter |
| fetch_i | input | 1 | Address is for an instruction fetch |
| ld_en_i | input | 1 | Direct register load enable |
| ld_idx_i | input | 3 | Register index for the load |
| ld_val_i | input | 32 | Value to load |
| rd_idx_i | input | 3 | Register index for the read port |
| rd_val_o | output | 32 | Contents of the register at rd_idx_i |
| ea_o | output | 32 | Effective address |
| wb_en_o | output | 1 | Register write-back requested |
| wb_val_o | output | 32 | Write-back value |
| misalign_o | output | 1 | Word or longword access at an odd address |

## Verification
Every mode is tried with register or field values whose sign bit is set and with values whose sign bit is clear. This tells sign extension apart from zero or ones filling, and a 16-bit extension apart from a full 32-bit add. Post-increment and pre-decrement are run at every operand size and across the wrap at zero and at all ones, which separates the three step sizes and shows which of the two values (before or after the change) becomes the address. Odd register values expose the misalignment flag, and a fetch address taken from a register with high bits set shows the masking. Short access sequences read back through the read port confirm that only strobed auto-modifying accesses change a register, and that a load beats a write-back to the same register.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int ADDR_W   = 32;
  localparam int FETCH_W  = 24;

  typedef enum logic [2:0] {
    AM_IND     = 3'd0,
    AM_DISP    = 3'd1,
    AM_POSTINC = 3'd2,
    AM_PREDEC  = 3'd3,
    AM_ABS     = 3'd4,
    AM_PCREL   = 3'd5
  } amode_e;

  localparam logic [1:0] FS_8  = 2'd0;
  localparam logic [1:0] FS_16 = 2'd1;
  localparam logic [1:0] FS_24 = 2'd2;
  localparam logic [1:0] FS_32 = 2'd3;

  localparam logic [1:0] OP_BYTE = 2'd0;
  localparam logic [1:0] OP_WORD = 2'd1;

  function automatic logic [ADDR_W-1:0] sx8(input logic [7:0] v);
    return {{(ADDR_W-8){v[7]}}, v};
  endfunction

  function automatic logic [ADDR_W-1:0] sx16(input logic [15:0] v);
    return {{(ADDR_W-16){v[15]}}, v};
  endfunction

  function automatic logic [ADDR_W-1:0] disp_ext(input logic [1:0] fsz,
                                                 input logic [ADDR_W-1:0] f);
    return (fsz == FS_16) ? sx16(f[15:0]) : f;
  endfunction

  function automatic logic [ADDR_W-1:0] pcrel_ext(input logic [1:0] fsz,
                                                  input logic [ADDR_W-1:0] f);
    return (fsz == FS_8) ? sx8(f[7:0]) : sx16(f[15:0]);
  endfunction

  function automatic logic [ADDR_W-1:0] abs_ext(input logic [1:0] fsz,
                                                input logic [ADDR_W-1:0] f);
    logic [ADDR_W-1:0] r;
    case (fsz)
      FS_8:    r = {{(ADDR_W-8){1'b1}}, f[7:0]};
      FS_16:   r = sx16(f[15:0]);
      FS_24:   r = {{(ADDR_W-24){1'b0}}, f[23:0]};
      default: r = f;
    endcase
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] step_amt(input logic [1:0] opsz);
    logic [ADDR_W-1:0] r;
    case (opsz)
      OP_BYTE: r = ADDR_W'(1);
      OP_WORD: r = ADDR_W'(2);
      default: r = ADDR_W'(4);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
(
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] regv_i,
  input  logic [ADDR_W-1:0] field_i,
  input  logic [1:0]        fsz_i,
  input  logic [1:0]        opsz_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              fetch_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_val_o,
  output logic              misalign_o
);
  logic [ADDR_W-1:0] raw_ea;
  logic [ADDR_W-1:0] stepv;
  logic              reg_based;

  assign stepv = step_amt(opsz_i);

  always_comb begin
    raw_ea    = '0;
    wb_en_o   = 1'b0;
    wb_val_o  = regv_i;
    reg_based = 1'b0;
    case (mode_i)
      AM_IND: begin
        raw_ea    = regv_i;
        reg_based = 1'b1;
      end
      AM_DISP: begin
        raw_ea    = regv_i + disp_ext(fsz_i, field_i);
        reg_based = 1'b1;
      end
      AM_POSTINC: begin
        raw_ea    = regv_i;
        wb_en_o   = 1'b1;
        wb_val_o  = regv_i + stepv;
        reg_based = 1'b1;
      end
      AM_PREDEC: begin
        raw_ea    = regv_i - stepv;
        wb_en_o   = 1'b1;
        wb_val_o  = regv_i - stepv;
        reg_based = 1'b1;
      end
      AM_ABS:   raw_ea = abs_ext(fsz_i, field_i);
      AM_PCREL: raw_ea = pc_i + pcrel_ext(fsz_i, field_i);
      default:  raw_ea = '0;
    endcase
  end

  assign ea_o = (fetch_i && reg_based)
              ? {{(ADDR_W-FETCH_W){1'b0}}, raw_ea[FETCH_W-1:0]}
              : raw_ea;

  assign misalign_o = (opsz_i != OP_BYTE) && ea_o[0];
endmodule

// File: rtl/ea_regfile.sv
module ea_regfile #(
  parameter int NREG = 8,
  parameter int W    = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_en_i,
  input  logic [IW-1:0]           ld_idx_i,
  input  logic [W-1:0]            ld_val_i,
  input  logic                    wb_en_i,
  input  logic [IW-1:0]           wb_idx_i,
  input  logic [W-1:0]            wb_val_i,
  output logic [NREG-1:0][W-1:0]  q_o
);
  for (genvar k = 0; k < NREG; k++) begin : g_ent
    logic hit_ld;
    logic hit_wb;
    assign hit_ld = ld_en_i && (ld_idx_i == IW'(k));
    assign hit_wb = wb_en_i && (wb_idx_i == IW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o[k] <= '0;
      else if (hit_ld) q_o[k] <= ld_val_i;
      else if (hit_wb) q_o[k] <= wb_val_i;
    end
  end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic [2:0]        mode_i,
  input  logic [IW-1:0]     reg_i,
  input  logic [ADDR_W-1:0] field_i,
  input  logic [1:0]        fsz_i,
  input  logic [1:0]        opsz_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              fetch_i,
  input  logic              ld_en_i,
  input  logic [IW-1:0]     ld_idx_i,
  input  logic [ADDR_W-1:0] ld_val_i,
  input  logic [IW-1:0]     rd_idx_i,
  output logic [ADDR_W-1:0] rd_val_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_val_o,
  output logic              misalign_o
);
  logic [NREG-1:0][ADDR_W-1:0] rf_q;
  logic [ADDR_W-1:0]           regv;
  logic                        wb_commit;

  assign regv      = rf_q[reg_i];
  assign wb_commit = step_i && wb_en_o;
  assign rd_val_o  = rf_q[rd_idx_i];

  ea_calc u_calc (
    .mode_i     (mode_i),
    .regv_i     (regv),
    .field_i    (field_i),
    .fsz_i      (fsz_i),
    .opsz_i     (opsz_i),
    .pc_i       (pc_i),
    .fetch_i    (fetch_i),
    .ea_o       (ea_o),
    .wb_en_o    (wb_en_o),
    .wb_val_o   (wb_val_o),
    .misalign_o (misalign_o)
  );

  ea_regfile #(.NREG(NREG), .W(ADDR_W)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en_i  (ld_en_i),
    .ld_idx_i (ld_idx_i),
    .ld_val_i (ld_val_i),
    .wb_en_i  (wb_commit),
    .wb_idx_i (reg_i),
    .wb_val_i (wb_val_o),
    .q_o      (rf_q)
  );
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [2:0]              mode_i,
  input logic [IW-1:0]           reg_i,
  input logic [1:0]              fsz_i,
  input logic [1:0]              opsz_i,
  input logic                    ld_en_i,
  input logic [IW-1:0]           ld_idx_i,
  input logic [31:0]             ld_val_i,
  input logic [31:0]             ea_o,
  input logic                    wb_en_o,
  input logic [31:0]             wb_val_o,
  input logic                    misalign_o,
  input logic                    wb_commit,
  input logic [NREG-1:0][31:0]   rf_q
);
  AST_POST_EA_IS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd2) |-> (ea_o[23:0] == rf_q[reg_i][23:0])); // R3

  AST_PRE_EA_EQ_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd3) |-> (wb_en_o && wb_val_o[23:0] == ea_o[23:0])); // R4

  AST_ABS8_UPPER_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd4 && fsz_i == 2'd0) |-> (ea_o[31:8] == 24'hFFFFFF)); // R5

  AST_WB_ONLY_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> (mode_i == 3'd2 || mode_i == 3'd3)); // R7

  AST_WB_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_commit && !(ld_en_i && ld_idx_i == reg_i))
      |=> (rf_q[$past(reg_i)] == $past(wb_val_o))); // R7

  AST_MISALIGN_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_o |-> (opsz_i != 2'd0 && ea_o[0])); // R8

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en_i |=> (rf_q[$past(ld_idx_i)] == $past(ld_val_i))); // R9
endmodule

bind ea_unit ea_unit_chk #(.NREG(NREG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_i     (mode_i),
  .reg_i      (reg_i),
  .fsz_i      (fsz_i),
  .opsz_i     (opsz_i),
  .ld_en_i    (ld_en_i),
  .ld_idx_i   (ld_idx_i),
  .ld_val_i   (ld_val_i),
  .ea_o       (ea_o),
  .wb_en_o    (wb_en_o),
  .wb_val_o   (wb_val_o),
  .misalign_o (misalign_o),
  .wb_commit  (wb_commit),
  .rf_q       (rf_q)
);

// File: tb/ea_unit_tb.sv
module ea_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  mode;
    logic [2:0]  idx;
    logic [31:0] regv;
    logic [31:0] field;
    logic [1:0]  fsz;
    logic [1:0]  opsz;
    logic [31:0] pc;
    logic        fetch;
    logic [31:0] ea;
    logic        wben;
    logic [31:0] wb;
    logic        mis;
  } vec_t;

  localparam vec_t VT [NV] = '{
    // R1 plain indirect
    '{4'd1, 3'd0, 3'd2, 32'h12345678, 32'h0, 2'd0, 2'd2, 32'h0, 1'b0, 32'h12345678, 1'b0, 32'h0, 1'b0},
    // R1 fetch masks upper byte
    '{4'd1, 3'd0, 3'd6, 32'hAB123457, 32'h0, 2'd0, 2'd0, 32'h0, 1'b1, 32'h00123457, 1'b0, 32'h0, 1'b0},
    // R2 16-bit negative displacement
    '{4'd2, 3'd1, 3'd1, 32'h00001000, 32'h0000FFF0, 2'd1, 2'd1, 32'h0, 1'b0, 32'h00000FF0, 1'b0, 32'h0, 1'b0},
    // R2 32-bit displacement unchanged
    '{4'd2, 3'd1, 3'd1, 32'h00001000, 32'h80000001, 2'd3, 2'd0, 32'h0, 1'b0, 32'h80001001, 1'b0, 32'h0, 1'b0},
    // R2 16-bit positive displacement with upper field bits ignored
    '{4'd2, 3'd1, 3'd4, 32'h00001000, 32'hFFFF0010, 2'd1, 2'd0, 32'h0, 1'b0, 32'h00001010, 1'b0, 32'h0, 1'b0},
    // R3 longword post-increment
    '{4'd3, 3'd2, 3'd5, 32'h00002000, 32'h0, 2'd0, 2'd2, 32'h0, 1'b0, 32'h00002000, 1'b1, 32'h00002004, 1'b0},
    // R3 byte post-increment wraps
    '{4'd3, 3'd2, 3'd5, 32'hFFFFFFFF, 32'h0, 2'd0, 2'd0, 32'h0, 1'b0, 32'hFFFFFFFF, 1'b1, 32'h00000000, 1'b0},
    // R3 word post-increment
    '{4'd3, 3'd2, 3'd0, 32'h00000010, 32'h0, 2'd0, 2'd1, 32'h0, 1'b0, 32'h00000010, 1'b1, 32'h00000012, 1'b0},
    // R4 word pre-decrement
    '{4'd4, 3'd3, 3'd7, 32'h00003000, 32'h0, 2'd0, 2'd1, 32'h0, 1'b0, 32'h00002FFE, 1'b1, 32'h00002FFE, 1'b0},
    // R4 longword pre-decrement wraps
    '{4'd4, 3'd3, 3'd7, 32'h00000000, 32'h0, 2'd0, 2'd3, 32'h0, 1'b0, 32'hFFFFFFFC, 1'b1, 32'hFFFFFFFC, 1'b0},
    // R5 abs 8-bit
    '{4'd5, 3'd4, 3'd0, 32'h0, 32'h00000012, 2'd0, 2'd0, 32'h0, 1'b0, 32'hFFFFFF12, 1'b0, 32'h0, 1'b0},
    // R5 abs 16-bit negative
    '{4'd5, 3'd4, 3'd0, 32'h0, 32'h00008000, 2'd1, 2'd1, 32'h0, 1'b0, 32'hFFFF8000, 1'b0, 32'h0, 1'b0},
    // R5 abs 16-bit positive
    '{4'd5, 3'd4, 3'd0, 32'h0, 32'hFFFF7FFE, 2'd1, 2'd1, 32'h0, 1'b0, 32'h00007FFE, 1'b0, 32'h0, 1'b0},
    // R5 abs 24-bit
    '{4'd5, 3'd4, 3'd0, 32'h0, 32'h12ABCDEF, 2'd2, 2'd0, 32'h0, 1'b0, 32'h00ABCDEF, 1'b0, 32'h0, 1'b0},
    // R5 abs 32-bit
    '{4'd5, 3'd4, 3'd0, 32'h0, 32'h12ABCDEF, 2'd3, 2'd0, 32'h0, 1'b0, 32'h12ABCDEF, 1'b0, 32'h0, 1'b0},
    // R6 pc-relative 8-bit negative
    '{4'd6, 3'd5, 3'd0, 32'h0, 32'h000000FE, 2'd0, 2'd0, 32'h00001000, 1'b0, 32'h00000FFE, 1'b0, 32'h0, 1'b0},
    // R6 pc-relative 16-bit positive
    '{4'd6, 3'd5, 3'd0, 32'h0, 32'h00000100, 2'd1, 2'd0, 32'h00001000, 1'b0, 32'h00001100, 1'b0, 32'h0, 1'b0},
    // R8 odd word pre-decrement still computed
    '{4'd8, 3'd3, 3'd3, 32'h00000005, 32'h0, 2'd0, 2'd1, 32'h0, 1'b0, 32'h00000003, 1'b1, 32'h00000003, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [2:0]  reg_i = '0;
  logic [31:0] field_i = '0;
  logic [1:0]  fsz_i = '0;
  logic [1:0]  opsz_i = '0;
  logic [31:0] pc_i = '0;
  logic        fetch_i = 1'b0;
  logic        ld_en_i = 1'b0;
  logic [2:0]  ld_idx_i = '0;
  logic [31:0] ld_val_i = '0;
  logic [2:0]  rd_idx_i = '0;
  logic [31:0] rd_val_o, ea_o, wb_val_o;
  logic        wb_en_o, misalign_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_unit u_dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .mode_i(mode_i), .reg_i(reg_i),
    .field_i(field_i), .fsz_i(fsz_i), .opsz_i(opsz_i), .pc_i(pc_i),
    .fetch_i(fetch_i), .ld_en_i(ld_en_i), .ld_idx_i(ld_idx_i),
    .ld_val_i(ld_val_i), .rd_idx_i(rd_idx_i), .rd_val_o(rd_val_o),
    .ea_o(ea_o), .wb_en_o(wb_en_o), .wb_val_o(wb_val_o), .misalign_o(misalign_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_reg(input logic [2:0] idx, input logic [31:0] val);
    ld_en_i = 1'b1; ld_idx_i = idx; ld_val_i = val;
    @(posedge clk); @(negedge clk);
    ld_en_i = 1'b0;
  endtask

  task automatic access(input logic [2:0] m, input logic [2:0] idx, input logic [1:0] os);
    mode_i = m; reg_i = idx; opsz_i = os; fetch_i = 1'b0; step_i = 1'b1;
    @(posedge clk); @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic read_reg(input string tag, input logic [2:0] idx, input logic [31:0] exp);
    rd_idx_i = idx;
    #1;
    check(tag, rd_val_o, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset clears every register
    for (int k = 0; k < 8; k++) read_reg("R9 reset value", 3'(k), 32'h0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      string t;
      load_reg(VT[v].idx, VT[v].regv);
      mode_i = VT[v].mode; reg_i = VT[v].idx; field_i = VT[v].field;
      fsz_i = VT[v].fsz; opsz_i = VT[v].opsz; pc_i = VT[v].pc;
      fetch_i = VT[v].fetch; step_i = 1'b0;
      #1;
      t = $sformatf("R%0d vec%0d ea", VT[v].req, v);
      check(t, ea_o, VT[v].ea);
      t = $sformatf("R7 vec%0d wb_en", v);
      check(t, {31'b0, wb_en_o}, {31'b0, VT[v].wben});
      if (VT[v].wben) begin
        t = $sformatf("R%0d vec%0d wb_val", VT[v].req, v);
        check(t, wb_val_o, VT[v].wb);
      end
      t = $sformatf("R8 vec%0d misalign", v);
      check(t, {31'b0, misalign_o}, {31'b0, VT[v].mis});
      @(negedge clk);
    end
    fetch_i = 1'b0;

    // R8 odd word indirect flags misalignment
    load_reg(3'd1, 32'h00000101);
    mode_i = 3'd0; reg_i = 3'd1; opsz_i = 2'd1; #1;
    check("R8 odd word ea", ea_o, 32'h00000101);
    check("R8 odd word flag", {31'b0, misalign_o}, 32'd1);
    opsz_i = 2'd0; #1;
    check("R8 odd byte no flag", {31'b0, misalign_o}, 32'd0);
    @(negedge clk);

    // R3 / R7 sequence of post-increments commits
    load_reg(3'd3, 32'h00000100);
    access(3'd2, 3'd3, 2'd2);
    access(3'd2, 3'd3, 2'd2);
    read_reg("R3 two longword post-increments", 3'd3, 32'h00000108);
    // R7 indirect access with strobe leaves register alone
    access(3'd0, 3'd3, 2'd2);
    read_reg("R7 indirect no change", 3'd3, 32'h00000108);
    // R7 auto mode without strobe leaves register alone
    mode_i = 3'd2; reg_i = 3'd3; step_i = 1'b0;
    @(posedge clk); @(negedge clk);
    read_reg("R7 no strobe no change", 3'd3, 32'h00000108);
    // R4 byte pre-decrement commits
    access(3'd3, 3'd3, 2'd0);
    read_reg("R4 byte pre-decrement", 3'd3, 32'h00000107);
    // R7 other registers untouched
    read_reg("R7 neighbour untouched", 3'd1, 32'h00000101);

    // R9 load wins over write-back to same register
    mode_i = 3'd2; reg_i = 3'd3; opsz_i = 2'd2; step_i = 1'b1;
    ld_en_i = 1'b1; ld_idx_i = 3'd3; ld_val_i = 32'hDEADBEE0;
    @(posedge clk); @(negedge clk);
    step_i = 1'b0; ld_en_i = 1'b0;
    read_reg("R9 load priority", 3'd3, 32'hDEADBEE0);

    // R9 load and write-back to different registers both land
    mode_i = 3'd3; reg_i = 3'd3; opsz_i = 2'd1; step_i = 1'b1;
    ld_en_i = 1'b1; ld_idx_i = 3'd4; ld_val_i = 32'h0000CAFE;
    @(posedge clk); @(negedge clk);
    step_i = 1'b0; ld_en_i = 1'b0;
    read_reg("R9 load other register", 3'd4, 32'h0000CAFE);
    read_reg("R4 concurrent pre-decrement", 3'd3, 32'hDEADBEDE);

    // R1 fetch masking also in displacement mode
    load_reg(3'd2, 32'hFF001000);
    mode_i = 3'd1; reg_i = 3'd2; field_i = 32'h00000020; fsz_i = 2'd1;
    opsz_i = 2'd0; fetch_i = 1'b1; #1;
    check("R1 fetch displacement mask", ea_o, 32'h00001020);
    fetch_i = 1'b0; #1;
    check("R2 data displacement full", ea_o, 32'hFF001020);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule